// File: doc/BRIEF.md
# PCI Slot Hotplug Event Register Bank

This block gives firmware a small register window for tracking slot hotplug activity on several PCI buses and for ordering slots to be ejected. Each bus has three 32-bit slot bitmaps: slots that gained a device, slots whose device should be removed, and slots that may be removed. A bus-select register decides which bus's bitmaps appear in the window. Plug and unplug strobes from the platform side set bits in these bitmaps and raise a general-purpose-event status bit. That bit, gated by an enable register, drives a level interrupt.

Firmware reads the insertion bitmap to learn about new devices. Outside legacy mode this read also empties it. Firmware writes an eject command for one slot and gets back a one-cycle eject pulse naming the bus and slot. A platform reset request, and also the hard reset, starts a sweep. The sweep turns every pending removal request into an eject, one slot per cycle. It then reloads the removable bitmaps from the per-slot hotplug-capable inputs. A legacy-mode strap shortens the window so that the select register is no longer decoded, and it keeps the insertion bitmap from clearing on read.

Top module: `hp_event_bank`

## Requirements
- R1: A plug strobe with bus index below the bus count sets bit [slot] of that bus's insertion bitmap (offset 0x00) and sets bit 1 (value 0x2) of `evt_sts`, both visible in the cycle after the strobe.
- R2: An unplug strobe with bus index below the bus count sets bit [slot] of that bus's removal bitmap (offset 0x04) and sets bit 1 of `evt_sts`.
- R3: A read of offset 0x00 returns the insertion bitmap of the selected bus. Outside legacy mode the bitmap is zero afterwards, except for a plug to that bus in the same cycle, whose bit survives. In legacy mode the read leaves the bitmap as it is.
- R4: A write to offset 0x08 with nonzero data acts only on the lowest set data bit. It clears that slot in both the insertion and removal bitmaps of the selected bus. One cycle later `eject_pulse` is high, with `eject_bus` and `eject_slot`, only if that slot's bit in `hp_capable` (index bus*32+slot) is 1.
- R5: An eject write is ignored (no bitmap change, no pulse) when the select value is at or above the bus count, or while a sweep is running.
- R6: A write to offset 0x10 loads the 32-bit select register, and a read of 0x10 returns it. In legacy mode, writes to 0x10 are ignored and reads of 0x10 return zero.
- R7: Reads of offsets 0x00, 0x04 and 0x0C return zero when the select value is at or above the bus count. Offset 0x08 and undecoded offsets always read as zero.
- R8: `irq` equals the OR of `evt_sts & evt_en`. `en_wr` loads `evt_en`. `sts_clr_wr` clears each `evt_sts` bit set in `sts_clr_data`. A new event in the same cycle wins over the clear.
- R9: A plug or unplug strobe whose bus index is at or above the bus count changes no bitmap and no status bit, and `event_err` is high for exactly the next cycle.
- R10: After hard reset or a `plat_reset` pulse, the sweep visits buses in ascending order and slots lowest first. Each cycle it clears one pending removal slot, in both bitmaps, and pulses eject if that slot is capable. When all removal bitmaps are empty it loads each bus's removable bitmap (offset 0x0C) from `hp_capable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | Strap: short window, no select decode, no clear on read |
| plat_reset | input | 1 | Pulse that starts a removal sweep |
| hp_capable | input | NUM_BUS*32 | Per-slot hotplug-capable flags, bus b slot s at b*32+s |
| plug_valid | input | 1 | Plug event strobe |
| plug_bus | input | EVT_BUS_W | Bus index of plug event |
| plug_slot | input | 5 | Slot number of plug event |
| unplug_valid | input | 1 | Unplug event strobe |
| unplug_bus | input | EVT_BUS_W | Bus index of unplug event |
| unplug_slot | input | 5 | Slot number of unplug event |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| sts_clr_wr | input | 1 | Write-one-to-clear strobe for event status |
| sts_clr_data | input | 8 | Status bits to clear |
| en_wr | input | 1 | Event enable write strobe |
| en_data | input | 8 | New event enable value |
| evt_sts | output | 8 | Event status register |
| evt_en | output | 8 | Event enable register |
| irq | output | 1 | Level interrupt |
| event_err | output | 1 | One-cycle pulse for a dropped event |
| eject_pulse | output | 1 | One-cycle eject command |
| eject_bus | output | BUS_W | Bus of the eject command |
| eject_slot | output | 5 | Slot of the eject command |

## Verification
The hardest state to reach is a sweep with removal requests pending on several buses at once. That state includes non-capable slots, which must be cleared silently, and capable slots whose stale insertion bits must be dropped. The bench builds this state with unplug and plug strobes on chosen buses. It then changes `hp_capable` so that the reload can be seen, pulses `plat_reset`, and collects every eject pulse in order to compare with a list computed from its model. A second hard-to-reach case is a plug strobe in the same cycle as a clearing read of the same bus. The bench drives both strobes in one cycle and confirms that the new bit survives while the read returns the old value.

// File: rtl/hp_pkg.sv
// Shared constants and helpers for the hotplug event register bank.
// Assumes a fixed 32-slot bitmap per bus and 32-bit register accesses.
package hp_pkg;
    localparam int SLOTS  = 32;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef logic [SLOTS-1:0] slot_map_t;

    localparam logic [4:0] OFS_INSERTED = 5'h00;
    localparam logic [4:0] OFS_REMOVAL  = 5'h04;
    localparam logic [4:0] OFS_EJECT    = 5'h08;
    localparam logic [4:0] OFS_REMOVABLE = 5'h0C;
    localparam logic [4:0] OFS_BUSSEL   = 5'h10;

    localparam int STS_HP_BIT = 1;

    // Index of the lowest set bit; zero when the map is empty.
    function automatic logic [SLOT_W-1:0] lowest_index(input slot_map_t m);
        logic [SLOT_W-1:0] idx;
        idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (m[i]) idx = SLOT_W'(i);
        end
        return idx;
    endfunction

    // Isolate the lowest set bit as a one-hot map.
    function automatic slot_map_t lowest_onehot(input slot_map_t m);
        return m & (~m + slot_map_t'(1));
    endfunction
endpackage

// File: rtl/hp_bus_slice.sv
// One bus worth of slot state: the insertion and removal bitmaps.
// Assumes set masks win over clear masks in the same cycle so that no
// event is lost when firmware reads or ejects at the same time.
module hp_bus_slice
    import hp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  slot_map_t set_up,
    input  slot_map_t set_down,
    input  slot_map_t clr_both,
    input  logic      clr_up_all,
    output slot_map_t up_map,
    output slot_map_t down_map
);
    // Update both bitmaps: clear first, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_map   <= '0;
            down_map <= '0;
        end else begin
            up_map   <= (up_map & ~clr_both & {SLOTS{~clr_up_all}}) | set_up;
            down_map <= (down_map & ~clr_both) | set_down;
        end
    end

    AST_PLUG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_up != '0) |=> ((up_map & $past(set_up)) == $past(set_up))); // R1
    AST_UNPLUG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_down != '0) |=> ((down_map & $past(set_down)) == $past(set_down))); // R2
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_up_all && set_up == '0) |=> (up_map == '0)); // R3
    AST_EJECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_both != '0 && set_down == '0) |=> ((down_map & $past(clr_both)) == '0)); // R4
endmodule

// File: rtl/hp_drain_seq.sv
// Removal sweep: walks the buses in ascending order and retires one pending
// removal slot per cycle, lowest slot first, then reports completion.
// Assumes the caller applies clr_mask to both bitmaps of clr_bus.
module hp_drain_seq
    import hp_pkg::*;
#(
    parameter int BUS_W = 2,
    localparam int NUM_BUS = 1 << BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  slot_map_t        down_maps [NUM_BUS],
    output logic             active,
    output logic             clr_valid,
    output logic [BUS_W-1:0] clr_bus,
    output slot_map_t        clr_mask,
    output logic             done
);
    logic [BUS_W-1:0] ptr;
    slot_map_t        cur;

    // Pick the lowest pending removal on the bus under the pointer.
    always_comb begin
        cur       = down_maps[ptr];
        clr_bus   = ptr;
        clr_valid = active && (cur != '0);
        clr_mask  = lowest_onehot(cur);
        done      = active && (cur == '0) && (ptr == BUS_W'(NUM_BUS - 1));
    end

    // Advance the pointer once a bus is empty; a hard reset starts a sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            ptr    <= '0;
        end else if (start) begin
            active <= 1'b1;
            ptr    <= '0;
        end else if (active && cur == '0) begin
            if (ptr == BUS_W'(NUM_BUS - 1)) active <= 1'b0;
            else                            ptr    <= ptr + 1'b1;
        end
    end

    AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !active); // R10
    AST_SWEEP_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !start) |=> (active && clr_bus == $past(clr_bus))); // R10
endmodule

// File: rtl/hp_event_bank.sv
// Hotplug event register bank: per-bus slot bitmaps behind a bus-select
// window, event status with enable and level interrupt, eject command
// output, and a removal sweep on reset. Assumes single-cycle register
// strobes with read data taken in the cycle of reg_rd.
module hp_event_bank
    import hp_pkg::*;
#(
    parameter int BUS_W     = 2,
    parameter int EVT_BUS_W = 8,
    localparam int NUM_BUS  = 1 << BUS_W,
    localparam int CAP_W    = NUM_BUS * SLOTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 legacy_mode,
    input  logic                 plat_reset,
    input  logic [CAP_W-1:0]     hp_capable,
    input  logic                 plug_valid,
    input  logic [EVT_BUS_W-1:0] plug_bus,
    input  logic [SLOT_W-1:0]    plug_slot,
    input  logic                 unplug_valid,
    input  logic [EVT_BUS_W-1:0] unplug_bus,
    input  logic [SLOT_W-1:0]    unplug_slot,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [4:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 sts_clr_wr,
    input  logic [7:0]           sts_clr_data,
    input  logic                 en_wr,
    input  logic [7:0]           en_data,
    output logic [7:0]           evt_sts,
    output logic [7:0]           evt_en,
    output logic                 irq,
    output logic                 event_err,
    output logic                 eject_pulse,
    output logic [BUS_W-1:0]     eject_bus,
    output logic [SLOT_W-1:0]    eject_slot
);
    slot_map_t up_maps   [NUM_BUS];
    slot_map_t down_maps [NUM_BUS];
    slot_map_t rmv_q     [NUM_BUS];

    logic [31:0]      sel_q;
    logic             sel_ok;
    logic [BUS_W-1:0] sel_idx;
    logic             plug_ok, unplug_ok;
    logic             ej_wr, ej_ok;
    slot_map_t        ej_onehot;
    logic             rd_clear;

    logic             dr_active, dr_valid, dr_done;
    logic [BUS_W-1:0] dr_bus;
    slot_map_t        dr_mask;

    logic             nx_pulse;
    logic [BUS_W-1:0] nx_bus;
    logic [SLOT_W-1:0] nx_slot;

    // Decode the select window and event bus ranges.
    always_comb begin
        sel_ok    = (sel_q >> BUS_W) == '0;
        sel_idx   = sel_q[BUS_W-1:0];
        plug_ok   = (plug_bus >> BUS_W) == '0;
        unplug_ok = (unplug_bus >> BUS_W) == '0;
        ej_wr     = reg_wr && reg_addr == OFS_EJECT;
        ej_ok     = ej_wr && sel_ok && !dr_active && reg_wdata != '0;
        ej_onehot = lowest_onehot(reg_wdata);
        rd_clear  = reg_rd && reg_addr == OFS_INSERTED && !legacy_mode && sel_ok;
    end

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        slot_map_t set_up, set_down, clr_both;
        logic      clr_up_all;

        // Route events, eject and sweep clears to this bus.
        always_comb begin
            set_up     = (plug_valid && plug_ok && plug_bus[BUS_W-1:0] == BUS_W'(b))
                         ? (slot_map_t'(1) << plug_slot) : '0;
            set_down   = (unplug_valid && unplug_ok && unplug_bus[BUS_W-1:0] == BUS_W'(b))
                         ? (slot_map_t'(1) << unplug_slot) : '0;
            clr_both   = ((ej_ok && sel_idx == BUS_W'(b)) ? ej_onehot : '0)
                       | ((dr_valid && dr_bus == BUS_W'(b)) ? dr_mask : '0);
            clr_up_all = rd_clear && sel_idx == BUS_W'(b);
        end

        hp_bus_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_up     (set_up),
            .set_down   (set_down),
            .clr_both   (clr_both),
            .clr_up_all (clr_up_all),
            .up_map     (up_maps[b]),
            .down_map   (down_maps[b])
        );

        // Removable bitmap: all ones from reset, reloaded when a sweep ends.
        always_ff @(posedge clk) begin
            if (!rst_n)       rmv_q[b] <= '1;
            else if (dr_done) rmv_q[b] <= hp_capable[b*SLOTS +: SLOTS];
        end
    end

    hp_drain_seq #(.BUS_W(BUS_W)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (plat_reset),
        .down_maps (down_maps),
        .active    (dr_active),
        .clr_valid (dr_valid),
        .clr_bus   (dr_bus),
        .clr_mask  (dr_mask),
        .done      (dr_done)
    );

    // Choose the eject source: the sweep has priority over register writes.
    always_comb begin
        if (dr_valid) begin
            nx_bus  = dr_bus;
            nx_slot = lowest_index(dr_mask);
        end else begin
            nx_bus  = sel_idx;
            nx_slot = lowest_index(reg_wdata);
        end
        nx_pulse = (dr_valid || ej_ok) && hp_capable[{nx_bus, nx_slot}];
    end

    // Register the eject command and the dropped-event flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eject_pulse <= 1'b0;
            eject_bus   <= '0;
            eject_slot  <= '0;
            event_err   <= 1'b0;
        end else begin
            eject_pulse <= nx_pulse;
            eject_bus   <= nx_bus;
            eject_slot  <= nx_slot;
            event_err   <= (plug_valid && !plug_ok) || (unplug_valid && !unplug_ok);
        end
    end

    // Select register, event status (write one to clear) and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            evt_sts <= '0;
            evt_en  <= '0;
        end else begin
            if (reg_wr && reg_addr == OFS_BUSSEL && !legacy_mode) sel_q <= reg_wdata;
            if (en_wr) evt_en <= en_data;
            evt_sts <= (evt_sts & ~(sts_clr_wr ? sts_clr_data : 8'h00))
                     | (8'((plug_valid && plug_ok) || (unplug_valid && unplug_ok)) << STS_HP_BIT);
        end
    end

    assign irq = |(evt_sts & evt_en);

    // Read mux over the selected bus.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_INSERTED:  if (sel_ok) reg_rdata = up_maps[sel_idx];
            OFS_REMOVAL:   if (sel_ok) reg_rdata = down_maps[sel_idx];
            OFS_REMOVABLE: if (sel_ok) reg_rdata = rmv_q[sel_idx];
            OFS_BUSSEL:    if (!legacy_mode) reg_rdata = sel_q;
            default:       reg_rdata = '0;
        endcase
    end

    AST_STATUS_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((plug_valid && plug_ok) || (unplug_valid && unplug_ok)) |=> evt_sts[STS_HP_BIT]); // R8
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        event_err |-> $past((plug_valid && !plug_ok) || (unplug_valid && !unplug_ok))); // R9
    AST_EJECT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        eject_pulse |-> $past(ej_ok || dr_valid)); // R4
    AST_NO_EJECT_OFF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ej_wr && !sel_ok && !dr_valid) |=> !eject_pulse); // R5
    AST_LEGACY_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_mode && !$past(legacy_mode) == 1'b0 && reg_wr && reg_addr == OFS_BUSSEL) |=> $stable(sel_q)); // R6
    AST_RMV_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_done && !plat_reset) |=> (rmv_q[0] == $past(hp_capable[SLOTS-1:0]))); // R10
endmodule

// File: tb/tb_hp_event_bank.sv
module tb_hp_event_bank;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic legacy_mode = 1'b0, plat_reset = 1'b0;
    logic [NB*32-1:0] hp_capable = '0;
    logic plug_valid = 1'b0, unplug_valid = 1'b0;
    logic [7:0] plug_bus = '0, unplug_bus = '0;
    logic [4:0] plug_slot = '0, unplug_slot = '0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic sts_clr_wr = 1'b0, en_wr = 1'b0;
    logic [7:0] sts_clr_data = '0, en_data = '0;
    logic [7:0] evt_sts, evt_en;
    logic irq, event_err, eject_pulse;
    logic [1:0] eject_bus;
    logic [4:0] eject_slot;

    hp_event_bank dut (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 0;

    logic [31:0] up_m [NB], dn_m [NB], cap_m [NB], rmv_m [NB];
    logic [31:0] sel_m = '0;
    logic [7:0]  sts_m = '0, en_m = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int low_bit(input logic [31:0] m);
        for (int i = 0; i < 32; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        if (a == 5'h10) return legacy_mode ? 32'h0 : sel_m;
        if (a == 5'h08 || sel_m >= NB) return 32'h0;
        case (a)
            5'h00: return up_m[sel_m[1:0]];
            5'h04: return dn_m[sel_m[1:0]];
            5'h0C: return rmv_m[sel_m[1:0]];
            default: return 32'h0;
        endcase
    endfunction

    task automatic apply_cap();
        for (int b = 0; b < NB; b++) hp_capable[b*32 +: 32] = cap_m[b];
    endtask

    task automatic do_plug(input logic [7:0] bus, input logic [4:0] slot);
        plug_valid = 1'b1; plug_bus = bus; plug_slot = slot;
        @(negedge clk);
        plug_valid = 1'b0;
        if (bus < NB) begin up_m[bus[1:0]][slot] = 1'b1; sts_m[1] = 1'b1; end
        chk("R9 err after plug", event_err, bus >= NB);
        chk("R1 status", evt_sts, sts_m);
        chk("R8 irq", irq, |(sts_m & en_m));
    endtask

    task automatic do_unplug(input logic [7:0] bus, input logic [4:0] slot);
        unplug_valid = 1'b1; unplug_bus = bus; unplug_slot = slot;
        @(negedge clk);
        unplug_valid = 1'b0;
        if (bus < NB) begin dn_m[bus[1:0]][slot] = 1'b1; sts_m[1] = 1'b1; end
        chk("R9 err after unplug", event_err, bus >= NB);
        chk("R2 status", evt_sts, sts_m);
    endtask

    task automatic do_read(input logic [4:0] a, input string req);
        reg_rd = 1'b1; reg_addr = a;
        #1 chk(req, reg_rdata, exp_read(a));
        @(negedge clk);
        reg_rd = 1'b0;
        if (a == 5'h00 && !legacy_mode && sel_m < NB) up_m[sel_m[1:0]] = '0;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        logic exp_p;
        int s;
        exp_p = 1'b0; s = 0;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 5'h10 && !legacy_mode) sel_m = d;
        if (a == 5'h08) begin
            if (sel_m < NB && d != 0) begin
                s = low_bit(d);
                up_m[sel_m[1:0]][s] = 1'b0;
                dn_m[sel_m[1:0]][s] = 1'b0;
                exp_p = cap_m[sel_m[1:0]][s];
            end
            chk("R4/R5 eject pulse", eject_pulse, exp_p);
            if (exp_p) begin
                chk("R4 eject bus", eject_bus, sel_m[1:0]);
                chk("R4 eject slot", eject_slot, s);
            end
        end
    endtask

    task automatic do_en(input logic [7:0] d);
        en_wr = 1'b1; en_data = d;
        @(negedge clk);
        en_wr = 1'b0; en_m = d;
        chk("R8 enable", evt_en, en_m);
        chk("R8 irq after enable", irq, |(sts_m & en_m));
    endtask

    task automatic do_clr(input logic [7:0] d);
        sts_clr_wr = 1'b1; sts_clr_data = d;
        @(negedge clk);
        sts_clr_wr = 1'b0; sts_m = sts_m & ~d;
        chk("R8 status clear", evt_sts, sts_m);
        chk("R8 irq after clear", irq, |(sts_m & en_m));
    endtask

    task automatic check_all_buses(input string req);
        logic [31:0] keep;
        keep = sel_m;
        for (int b = 0; b < NB; b++) begin
            do_write(5'h10, b);
            do_read(5'h00, req);
            do_read(5'h04, req);
            do_read(5'h0C, req);
        end
        do_write(5'h10, keep);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_list [256];
        logic [31:0] got_list [256];
        int n_exp, n_got;
        void'($urandom(32'h5EED_0042));
        for (int b = 0; b < NB; b++) begin
            up_m[b] = '0; dn_m[b] = '0; cap_m[b] = $urandom; rmv_m[b] = cap_m[b];
        end
        cap_m[2][3] = 1'b1; cap_m[2][7] = 1'b0;
        rmv_m[2] = cap_m[2];
        apply_cap();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R8 reset status", evt_sts, 8'h0);
        chk("R8 reset irq", irq, 1'b0);
        chk("R4 reset eject", eject_pulse, 1'b0);
        repeat (8) @(negedge clk);

        // R10: hard reset sweep loads removable bitmaps from capable flags.
        check_all_buses("R10 after reset");
        // R7 / R6: out-of-window select.
        do_write(5'h10, 32'd7);
        do_read(5'h00, "R7 oor inserted");
        do_read(5'h0C, "R7 oor removable");
        do_read(5'h10, "R6 select readback");
        do_write(5'h10, 32'd1);
        do_read(5'h08, "R7 eject offset reads zero");
        do_read(5'h14, "R7 undecoded offset");

        // R1 / R3: insertion bit then clearing read.
        do_plug(8'd1, 5'd5);
        do_read(5'h00, "R1 inserted bit");
        do_read(5'h00, "R3 cleared after read");

        // R9: bad bus index.
        do_plug(8'd9, 5'd2);
        do_unplug(8'd200, 5'd4);
        check_all_buses("R9 no bitmap change");

        // R8: enable, interrupt, write-one-to-clear.
        do_en(8'h02);
        do_clr(8'h02);
        do_unplug(8'd0, 5'd1);
        do_en(8'h00);
        do_en(8'h02);
        // R8: event in same cycle as clear wins.
        plug_valid = 1'b1; plug_bus = 8'd3; plug_slot = 5'd9;
        sts_clr_wr = 1'b1; sts_clr_data = 8'h02;
        @(negedge clk);
        plug_valid = 1'b0; sts_clr_wr = 1'b0; up_m[3][9] = 1'b1;
        chk("R8 set wins over clear", evt_sts[1], 1'b1);
        do_clr(8'hFF);

        // R4: eject lowest bit, clears both bitmaps.
        do_unplug(8'd2, 5'd3);
        do_unplug(8'd2, 5'd7);
        do_plug(8'd2, 5'd3);
        do_write(5'h10, 32'd2);
        do_write(5'h08, 32'h0000_0088);
        do_read(5'h04, "R4 removal after eject");
        do_write(5'h08, 32'h0000_0080);
        do_read(5'h04, "R4 non-capable removal cleared");

        // R5: eject with select out of window is ignored.
        do_unplug(8'd2, 5'd11);
        do_write(5'h10, 32'd6);
        do_write(5'h08, 32'h0000_0800);
        do_write(5'h10, 32'd2);
        do_read(5'h04, "R5 removal kept");

        // R3 corner: plug lands in the same cycle as a clearing read.
        do_plug(8'd2, 5'd0);
        reg_rd = 1'b1; reg_addr = 5'h00;
        plug_valid = 1'b1; plug_bus = 8'd2; plug_slot = 5'd20;
        #1 chk("R3 read returns old value", reg_rdata, up_m[2]);
        @(negedge clk);
        reg_rd = 1'b0; plug_valid = 1'b0;
        up_m[2] = 32'h0010_0000; sts_m[1] = 1'b1;
        do_read(5'h00, "R3 same-cycle plug survives");

        // R6 / R3: legacy mode.
        legacy_mode = 1'b1;
        do_write(5'h10, 32'd3);
        do_read(5'h10, "R6 legacy select reads zero");
        do_plug(8'd2, 5'd1);
        do_read(5'h00, "R3 legacy read");
        do_read(5'h00, "R3 legacy no clear");
        legacy_mode = 1'b0;
        do_read(5'h10, "R6 select kept");
        do_read(5'h00, "R3 clear after legacy");

        // Random mix checked against the model.
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 7;
            case (r)
                0: do_plug(8'($urandom % 5), 5'($urandom));
                1: do_unplug(8'($urandom % 5), 5'($urandom));
                2: begin
                    int k;
                    k = $urandom % 5;
                    do_read(5'(k * 4), "R7 random read");
                end
                3: do_write(5'h10, $urandom % 6);
                4: do_write(5'h08, ($urandom % 3 == 0) ? 32'h0 : ($urandom & $urandom));
                5: do_en(8'($urandom));
                default: do_clr(8'($urandom));
            endcase
        end

        // R10: sweep with pending removals on several buses.
        do_unplug(8'd0, 5'd4);
        do_unplug(8'd0, 5'd31);
        do_unplug(8'd1, 5'd0);
        do_unplug(8'd3, 5'd17);
        do_unplug(8'd3, 5'd2);
        do_plug(8'd3, 5'd2);
        for (int b = 0; b < NB; b++) cap_m[b] = $urandom;
        cap_m[0][4] = 1'b1; cap_m[3][17] = 1'b0;
        apply_cap();
        n_exp = 0;
        for (int b = 0; b < NB; b++) begin
            while (dn_m[b] != 0) begin
                int s;
                s = low_bit(dn_m[b]);
                if (cap_m[b][s]) begin exp_list[n_exp] = {b[15:0], 16'(s)}; n_exp++; end
                dn_m[b][s] = 1'b0;
                up_m[b][s] = 1'b0;
            end
            rmv_m[b] = cap_m[b];
        end
        plat_reset = 1'b1;
        @(negedge clk);
        plat_reset = 1'b0;
        n_got = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (eject_pulse && n_got < 256) begin
                got_list[n_got] = {14'h0, eject_bus, 11'h0, eject_slot};
                n_got++;
            end
        end
        chk("R10 sweep pulse count", n_got, n_exp);
        for (int k = 0; k < n_exp && k < n_got; k++)
            chk("R10 sweep order", got_list[k], exp_list[k]);
        check_all_buses("R10 after sweep");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule